// File: doc/BRIEF.md
# Memory Access Port Register Emulator

This block presents the register file of a debug memory access port to a register-side initiator and turns each register access that targets memory into a single word access on a simple memory bus. It keeps two stored registers: a control word and a transfer address. It also serves a data window that reads or writes memory at the transfer address. A group of four banked windows reaches the four words of the 16-byte line that holds the transfer address.

The initiator raises `host_req` for one cycle with a register offset, a direction and write data. `host_busy` is high from the cycle after acceptance until the reply. `host_done` pulses once together with the read data. Only one memory request can be in flight at any time. An access to an offset the block does not decode raises a sticky error flag. A separate `stat_rd` strobe reads that flag and clears it.

The controller has four states. S_IDLE accepts requests. S_ISSUE holds a bus request until the bus accepts it. S_AWAIT waits for the bus response. S_REPLY presents the reply for one cycle. The transitions are:
- accept_reg: S_IDLE to S_REPLY, for a request that needs no bus access.
- accept_mem: S_IDLE to S_ISSUE, for a data or banked window access.
- granted: S_ISSUE to S_AWAIT, on `mem_req_ready`.
- responded: S_AWAIT to S_REPLY, on `mem_rsp_valid`.
- retire: S_REPLY to S_IDLE, always after one cycle.

Top module: `memport_regemu`

## Requirements
- R1: A write to the control word (offset 0x00) stores the written value with bits [2:0] replaced by 3'b010, which is the word-size code. A read returns the stored value.
- R2: A write to the transfer address (offset 0x04) stores the value with bits [1:0] forced to zero. A read returns the stored value.
- R3: A data window access (offset 0x0C) issues a bus access at the transfer address. Afterwards the transfer address grows by 1 << control[2:0] bytes (4 bytes) when control[5:4] is non-zero, and stays unchanged when control[5:4] is zero.
- R4: A banked window access (offsets 0x10, 0x14, 0x18, 0x1C) issues a bus access at the transfer address with bits [3:0] replaced by offset[3:2] followed by 2'b00. The transfer address does not change.
- R5: The most significant bit of every bus address is zero, whatever the transfer address holds.
- R6: Offsets 0xF4, 0xF8 and 0xFC read as zero. Writes to them change nothing, and none of these accesses reaches the bus.
- R7: Any other offset sets `err_flag`, replies with zero data, and issues no bus access.
- R8: `err_flag` stays set until a `stat_rd` strobe. It reads zero from the cycle after that strobe, unless a new error arrives at the same time.
- R9: `host_busy` is high while an access is in progress, and a `host_req` raised during that time is ignored. A bus request holds its address, direction and data until `mem_req_ready`.
- R10: After reset, both stored registers are zero, `err_flag` is clear, and `host_busy`, `host_done` and `mem_req_valid` are low.
- R11: `host_done` is a single-cycle pulse. A window read returns `mem_rdata` from the bus response, and every write replies with zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_req | input | 1 | Register access strobe, sampled while idle |
| host_we | input | 1 | 1 = write, 0 = read |
| host_off | input | OFF_W | Register byte offset |
| host_wdata | input | DATA_W | Register write data |
| host_busy | output | 1 | An access is in progress |
| host_done | output | 1 | Reply pulse |
| host_rdata | output | DATA_W | Read data, valid with host_done |
| stat_rd | input | 1 | Error status read strobe; clears the flag |
| err_flag | output | 1 | Sticky error flag |
| mem_req_valid | output | 1 | Bus request valid |
| mem_req_ready | input | 1 | Bus accepts the request |
| mem_we | output | 1 | Bus request is a write |
| mem_addr | output | ADDR_W | Bus byte address |
| mem_wdata | output | DATA_W | Bus write data |
| mem_rsp_valid | input | 1 | Bus response valid |
| mem_rdata | input | DATA_W | Bus read data |

## Verification
The hardest case to reach is a new request arriving while a window access is still stalled at the bus. In that case the transfer address must keep its old value. The bench keeps `host_req` raised with a write to the transfer address in the cycle after a data window access is accepted. It then reads the address back. Random bus ready and response delays keep requests pending for several cycles. Random control values alternate between increment on and off. Random transfer addresses often have the top bit set, so stripping that bit and the low-nibble replacement are exercised across many lines.

// File: rtl/memport_pkg.sv
package memport_pkg;

    // Register offsets. The banked window offsets carry their word select
    // in bits [3:2], which the address generator relies on.
    localparam logic [7:0] OFF_CTRL  = 8'h00;
    localparam logic [7:0] OFF_XADDR = 8'h04;
    localparam logic [7:0] OFF_DWIN  = 8'h0C;
    localparam logic [7:0] OFF_BANK0 = 8'h10;
    localparam logic [7:0] OFF_BANK3 = 8'h1C;
    localparam logic [7:0] OFF_CFGZ  = 8'hF4;
    localparam logic [7:0] OFF_BASEZ = 8'hF8;
    localparam logic [7:0] OFF_IDZ   = 8'hFC;

    // Word-size code forced into the control word.
    localparam logic [2:0] SIZE_WORD = 3'b010;

    typedef enum logic [2:0] {
        K_CTRL,
        K_XADDR,
        K_DWIN,
        K_BANK,
        K_ZERO,
        K_BAD
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE,
        S_ISSUE,
        S_AWAIT,
        S_REPLY
    } state_e;

endpackage

// File: rtl/memport_decode.sv
module memport_decode
    import memport_pkg::*;
#(
    parameter int OFF_W = 8
) (
    input  logic [OFF_W-1:0] off,
    output kind_e            kind
);

    logic aligned;
    assign aligned = (off[1:0] == 2'b00);

    always_comb begin
        kind = K_BAD;
        if (off == OFF_W'(OFF_CTRL)) begin
            kind = K_CTRL;
        end else if (off == OFF_W'(OFF_XADDR)) begin
            kind = K_XADDR;
        end else if (off == OFF_W'(OFF_DWIN)) begin
            kind = K_DWIN;
        end else if (aligned && off >= OFF_W'(OFF_BANK0) && off <= OFF_W'(OFF_BANK3)) begin
            kind = K_BANK;
        end else if (off == OFF_W'(OFF_CFGZ) || off == OFF_W'(OFF_BASEZ) ||
                     off == OFF_W'(OFF_IDZ)) begin
            kind = K_ZERO;
        end
    end

endmodule

// File: rtl/memport_addr_gen.sv
module memport_addr_gen #(
    parameter int ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] xaddr,
    input  logic [1:0]        word_sel,
    input  logic              banked,
    input  logic [1:0]        inc_mode,
    input  logic [2:0]        size_code,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [ADDR_W-1:0] xaddr_next
);

    localparam int STRIP_MSB = ADDR_W - 1;

    logic [ADDR_W-1:0] raw;
    logic [ADDR_W-1:0] step;

    always_comb begin
        if (banked) begin
            raw = {xaddr[ADDR_W-1:4], word_sel, 2'b00};
        end else begin
            raw = xaddr;
        end
        bus_addr = raw;
        bus_addr[STRIP_MSB] = 1'b0;
    end

    always_comb begin
        if (inc_mode != 2'b00) begin
            step = ADDR_W'(1) << size_code;
        end else begin
            step = '0;
        end
        xaddr_next = xaddr + step;
    end

endmodule

// File: rtl/memport_regs.sv
module memport_regs
    import memport_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_xaddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xaddr_adv,
    input  logic [ADDR_W-1:0] xaddr_next,
    input  logic              err_set,
    input  logic              err_clr,
    output logic [DATA_W-1:0] ctrl_q,
    output logic [ADDR_W-1:0] xaddr_q,
    output logic              err_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q <= {wdata[DATA_W-1:3], SIZE_WORD};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            xaddr_q <= '0;
        end else if (wr_xaddr) begin
            xaddr_q <= {wdata[ADDR_W-1:2], 2'b00};
        end else if (xaddr_adv) begin
            xaddr_q <= xaddr_next;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_set) begin
            err_q <= 1'b1;
        end else if (err_clr) begin
            err_q <= 1'b0;
        end
    end

endmodule

// File: rtl/memport_regemu.sv
module memport_regemu
    import memport_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    parameter int OFF_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic              host_we,
    input  logic [OFF_W-1:0]  host_off,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_busy,
    output logic              host_done,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              stat_rd,
    output logic              err_flag,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rsp_valid,
    input  logic [DATA_W-1:0] mem_rdata
);

    state_e            state;
    state_e            state_nx;
    kind_e             kind;
    logic              accept;
    logic              to_bus;
    logic [DATA_W-1:0] ctrl_q;
    logic [ADDR_W-1:0] xaddr_q;
    logic [ADDR_W-1:0] xaddr_next;
    logic [ADDR_W-1:0] calc_addr;
    logic              err_q;
    logic              op_we;
    logic              op_dwin;
    logic [ADDR_W-1:0] op_addr;
    logic [DATA_W-1:0] op_wdata;
    logic [DATA_W-1:0] rdata_q;
    logic              xaddr_adv;

    memport_decode #(.OFF_W(OFF_W)) u_decode (
        .off  (host_off),
        .kind (kind)
    );

    memport_addr_gen #(.ADDR_W(ADDR_W)) u_addr (
        .xaddr      (xaddr_q),
        .word_sel   (host_off[3:2]),
        .banked     (kind == K_BANK),
        .inc_mode   (ctrl_q[5:4]),
        .size_code  (ctrl_q[2:0]),
        .bus_addr   (calc_addr),
        .xaddr_next (xaddr_next)
    );

    assign accept    = (state == S_IDLE) && host_req;
    assign to_bus    = (kind == K_DWIN) || (kind == K_BANK);
    assign xaddr_adv = (state == S_AWAIT) && mem_rsp_valid && op_dwin;

    memport_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_ctrl    (accept && host_we && kind == K_CTRL),
        .wr_xaddr   (accept && host_we && kind == K_XADDR),
        .wdata      (host_wdata),
        .xaddr_adv  (xaddr_adv),
        .xaddr_next (xaddr_next),
        .err_set    (accept && kind == K_BAD),
        .err_clr    (stat_rd),
        .ctrl_q     (ctrl_q),
        .xaddr_q    (xaddr_q),
        .err_q      (err_q)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= S_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    // Transitions
    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (host_req) state_nx = to_bus ? S_ISSUE : S_REPLY;
            S_ISSUE: if (mem_req_ready) state_nx = S_AWAIT;
            S_AWAIT: if (mem_rsp_valid) state_nx = S_REPLY;
            S_REPLY: state_nx = S_IDLE;
        endcase
    end

    // Operation and reply data capture
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_we    <= 1'b0;
            op_dwin  <= 1'b0;
            op_addr  <= '0;
            op_wdata <= '0;
            rdata_q  <= '0;
        end else if (accept) begin
            op_we    <= host_we;
            op_dwin  <= (kind == K_DWIN);
            op_addr  <= calc_addr;
            op_wdata <= host_wdata;
            if (!host_we && kind == K_CTRL) begin
                rdata_q <= ctrl_q;
            end else if (!host_we && kind == K_XADDR) begin
                rdata_q <= DATA_W'(xaddr_q);
            end else begin
                rdata_q <= '0;
            end
        end else if (state == S_AWAIT && mem_rsp_valid) begin
            rdata_q <= op_we ? '0 : mem_rdata;
        end
    end

    // Outputs
    always_comb begin
        host_busy     = (state != S_IDLE);
        host_done     = (state == S_REPLY);
        host_rdata    = rdata_q;
        err_flag      = err_q;
        mem_req_valid = (state == S_ISSUE);
        mem_we        = op_we;
        mem_addr      = op_addr;
        mem_wdata     = op_wdata;
    end

endmodule

// File: rtl/memport_regemu_chk.sv
module memport_regemu_chk #(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              host_busy,
    input logic              host_done,
    input logic              stat_rd,
    input logic              err_flag,
    input logic              mem_req_valid,
    input logic              mem_req_ready,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_wdata
);

    AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_addr) &&
        $stable(mem_we) && $stable(mem_wdata)); // R9

    AST_BUS_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> host_busy); // R9

    AST_ADDR_MSB_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !mem_addr[ADDR_W-1]); // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        host_done |=> !host_done); // R11

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        err_flag && !stat_rd |=> err_flag); // R8

    AST_ERR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        stat_rd && host_busy |=> !err_flag); // R8

endmodule

bind memport_regemu memport_regemu_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .host_busy     (host_busy),
    .host_done     (host_done),
    .stat_rd       (stat_rd),
    .err_flag      (err_flag),
    .mem_req_valid (mem_req_valid),
    .mem_req_ready (mem_req_ready),
    .mem_we        (mem_we),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata)
);

// File: tb/memport_regemu_tb.sv
`timescale 1ns/1ps
module memport_regemu_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_req = 1'b0;
    logic        host_we = 1'b0;
    logic [7:0]  host_off = 8'h00;
    logic [31:0] host_wdata = '0;
    logic        host_busy;
    logic        host_done;
    logic [31:0] host_rdata;
    logic        stat_rd = 1'b0;
    logic        err_flag;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_we;
    logic [31:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rdata = '0;

    always #4 clk = ~clk;

    memport_regemu u_dut (
        .clk(clk), .rst_n(rst_n), .host_req(host_req), .host_we(host_we),
        .host_off(host_off), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_done(host_done), .host_rdata(host_rdata), .stat_rd(stat_rd),
        .err_flag(err_flag), .mem_req_valid(mem_req_valid),
        .mem_req_ready(mem_req_ready), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rsp_valid(mem_rsp_valid), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] bmem [64];
    logic [31:0] m_ctrl = '0;
    logic [31:0] m_xaddr = '0;
    logic        m_err = 1'b0;
    logic [31:0] last_rd, last_addr, last_wd;
    logic        last_we, last_saw, last_got;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    // kind codes: 0 ctrl, 1 xaddr, 2 data window, 3 bank, 4 zero, 5 bad
    function automatic int kind_of(input logic [7:0] off);
        if (off == 8'h00) return 0;
        if (off == 8'h04) return 1;
        if (off == 8'h0C) return 2;
        if (off == 8'h10 || off == 8'h14 || off == 8'h18 || off == 8'h1C) return 3;
        if (off == 8'hF4 || off == 8'hF8 || off == 8'hFC) return 4;
        return 5;
    endfunction

    task automatic do_acc(input logic we, input logic [7:0] off, input logic [31:0] wd,
                          input bit inject);
        bit acc = 0;
        bit resp = 0;
        last_saw = 0; last_got = 0;
        @(negedge clk);
        host_req = 1; host_we = we; host_off = off; host_wdata = wd;
        for (int c = 0; c < 200 && !last_got; c++) begin
            @(negedge clk);
            host_req = 0; mem_req_ready = 0; mem_rsp_valid = 0;
            if (inject && c == 0) begin
                host_req = 1; host_we = 1; host_off = 8'h04; host_wdata = 32'h1234_5670;
            end
            if (host_done) begin
                last_got = 1; last_rd = host_rdata;
            end else if (mem_req_valid && !acc) begin
                if (!last_saw) begin
                    last_saw = 1; last_addr = mem_addr; last_we = mem_we; last_wd = mem_wdata;
                end
                if ($urandom % 3 != 0) begin
                    mem_req_ready = 1; acc = 1;
                    if (mem_we) bmem[mem_addr[7:2]] = mem_wdata;
                end
            end else if (acc && !resp) begin
                if ($urandom % 2 == 1) begin
                    mem_rsp_valid = 1; mem_rdata = bmem[last_addr[7:2]]; resp = 1;
                end
            end
        end
        host_req = 0;
        if (!last_got) chk("R11 reply", 32'd0, 32'd1);
    endtask

    task automatic run_op(input logic we, input logic [7:0] off, input logic [31:0] wd,
                          input bit inject);
        int k = kind_of(off);
        logic [31:0] ea = '0;
        logic [31:0] er = '0;
        if (k == 2) ea = m_xaddr & 32'h7FFF_FFFF;
        if (k == 3) ea = {m_xaddr[31:4], 4'b0000} | {28'd0, off[3:2], 2'b00};
        ea[31] = 1'b0;
        if (!we && (k == 2 || k == 3)) er = bmem[ea[7:2]];
        if (!we && k == 0) er = m_ctrl;
        if (!we && k == 1) er = m_xaddr;
        do_acc(we, off, wd, inject);
        if (we && k == 0) m_ctrl = {wd[31:3], 3'b010};
        if (we && k == 1) m_xaddr = {wd[31:2], 2'b00};
        if (k == 2 && m_ctrl[5:4] != 2'b00) m_xaddr = m_xaddr + (32'd1 << m_ctrl[2:0]);
        if (k == 5) m_err = 1'b1;
        case (k)
            0: chk("R1 ctrl reply", last_rd, er);
            1: chk("R2 xaddr reply", last_rd, er);
            4: chk("R6 zero reply", last_rd, er);
            5: chk("R7 bad reply", last_rd, er);
            default: chk("R11 window reply", last_rd, er);
        endcase
        if (k == 2 || k == 3) begin
            chk(k == 2 ? "R3 bus seen" : "R4 bus seen", {31'd0, last_saw}, 32'd1);
            chk(k == 2 ? "R3 addr" : "R4 addr", last_addr, ea);
            chk("R5 addr msb", {31'd0, last_addr[31]}, 32'd0);
            chk("R11 bus dir", {31'd0, last_we}, {31'd0, we});
            if (we) chk("R11 bus wdata", last_wd, wd);
        end else begin
            chk(k == 5 ? "R7 no bus" : "R6 no bus", {31'd0, last_saw}, 32'd0);
        end
        chk("R7 err flag", {31'd0, err_flag}, {31'd0, m_err});
    endtask

    task automatic stat_read();
        @(negedge clk);
        chk("R8 err value", {31'd0, err_flag}, {31'd0, m_err});
        stat_rd = 1;
        @(negedge clk);
        stat_rd = 0;
        m_err = 0;
        chk("R8 err cleared", {31'd0, err_flag}, 32'd0);
    endtask

    initial begin
        #1_400_000;
        chk("watchdog", 32'd0, 32'd1);
        finish_run();
    end

    initial begin
        logic [7:0] pool [14];
        pool = '{8'h00, 8'h04, 8'h0C, 8'h0C, 8'h10, 8'h14, 8'h18, 8'h1C,
                 8'hF4, 8'hF8, 8'hFC, 8'h08, 8'h24, 8'h0D};
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 64; i++) bmem[i] = 32'hA500_0000 + i;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk("R10 busy", {31'd0, host_busy}, 32'd0);
        chk("R10 done", {31'd0, host_done}, 32'd0);
        chk("R10 bus valid", {31'd0, mem_req_valid}, 32'd0);
        chk("R10 err", {31'd0, err_flag}, 32'd0);
        rst_n = 1;
        run_op(0, 8'h00, 0, 0);   // R10 ctrl zero
        run_op(0, 8'h04, 0, 0);   // R10 xaddr zero
        // R1 size field forced
        run_op(1, 8'h00, 32'hFFFF_FF35, 0);
        run_op(0, 8'h00, 0, 0);
        // R2 low bits cleared, R5 top bit set in stored address
        run_op(1, 8'h04, 32'h8000_0107, 0);
        run_op(0, 8'h04, 0, 0);
        // R3 increment by 4
        run_op(1, 8'h0C, 32'hCAFE_0001, 0);
        run_op(0, 8'h04, 0, 0);
        // R4 bank access, xaddr unchanged
        run_op(0, 8'h18, 0, 0);
        run_op(1, 8'h1C, 32'h0BAD_F00D, 0);
        run_op(0, 8'h04, 0, 0);
        // R3 no increment
        run_op(1, 8'h00, 32'h0000_0002, 0);
        run_op(0, 8'h0C, 0, 0);
        run_op(0, 8'h0C, 0, 0);
        run_op(0, 8'h04, 0, 0);
        // R6 zero registers
        run_op(1, 8'hF4, 32'hFFFF_FFFF, 0);
        run_op(0, 8'hF4, 0, 0);
        run_op(0, 8'hFC, 0, 0);
        // R7 / R8 error flag
        run_op(0, 8'h08, 0, 0);
        run_op(0, 8'h00, 0, 0);
        stat_read();
        // R9 request while busy is ignored
        run_op(1, 8'h00, 32'h0000_0012, 0);
        run_op(0, 8'h0C, 0, 1);
        run_op(0, 8'h04, 0, 0);
        chk("R9 ignored while busy", last_rd, m_xaddr);
        // random mix
        for (int i = 0; i < 500; i++) begin
            logic [7:0] off = pool[$urandom % 14];
            logic [31:0] wd = $urandom;
            if (off == 8'h00) wd[5:4] = 2'($urandom % 4);
            run_op(1'($urandom % 2), off, wd, ($urandom % 8 == 0) && off == 8'h0C);
            if ($urandom % 6 == 0) stat_read();
        end
        finish_run();
    end

endmodule